// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block powers a contact smart card up and down in a fixed order for a host controller. The host asks for a session by pulling an active-low request line. The block then steps the card supply enable, the I/O enable, the card clock gate and the card reset through a timed activation. When the request is released, the outputs step back down in the reverse order. Fault flags (supply overcurrent, overtemperature, low host supply) and card removal during a session trigger the same shutdown order automatically. An active-low status line reports the reason to the host.

All timing comes from a slow oscillator tick, one clock-wide pulse per oscillator period. The milestone unit T is `OSC_PER_T` ticks, and every milestone falls on a multiple of half a T. Card presence is debounced over `DEB_TICKS` ticks on insertion and is dropped at once on removal. With the request released and both voltage-select inputs high, the block enters a stop state. It leaves that state through a power-up hold of `PU_TICKS` ticks, followed by a fresh debounce.

Every pin is a plain level, so there is no stream interface and no back-pressure. Counting of ticks starts at the clock edge that registers a change, and in the timings below H is `OSC_PER_T/2` ticks.

Top module: `sc_session_seq`

## Requirements
- R1: While reset is held, vcc_en, io_en, clk_en, card_rst and stat_n are all 0, and vcc_sel is 2'b00.
- R2: vcc_sel is registered from the select inputs one cycle later. It is 2'b10 (1.8 V) whenever sel_1v8 is high, whatever sel_5v is. Otherwise it is 2'b01 (5 V) when sel_5v is high and 2'b00 (3 V) when it is low.
- R3: A session starts when sess_req_n is low in the inactive state with a debounced card and no latched fault. vcc_en rises on the next edge. io_en rises once 8H ticks have been counted in activation. The reset-enable point falls at 14H ticks.
- R4: card_rst is 0 before the reset-enable point. After that point it follows host_rst in the same cycle.
- R5: If host_rst was low when activation began, clk_en rises together with io_en. If it was high, clk_en rises in the cycle host_rst is low at or after the I/O-enable point, and at the latest at the reset-enable point. Once running, the clock no longer depends on host_rst.
- R6: Raising sess_req_n in a session clears card_rst on the next edge. clk_en then falls after H ticks, io_en after 2H ticks and vcc_en after 3H ticks, and the block is inactive again after 4H ticks.
- R7: A request that goes low during deactivation does not stop or restart it. It is acted on in the first cycle back in the inactive state.
- R8: The debounced presence becomes 1 only after card_det has been high for DEB_TICKS consecutive ticks. Any low cycle restarts the count.
- R9: card_det low during a session clears the debounced presence and starts a shutdown on the next edge, so stat_n is 0 one cycle later.
- R10: fault_ovc, fault_hot or fault_vlow during a session makes stat_n 0 and starts the shutdown on the next edge. stat_n stays 0, and no new session starts, until sess_req_n is seen high in the inactive state.
- R11: Outside a session, stat_n equals the debounced presence, and fault_ovc and fault_hot have no effect on it.
- R12: With sess_req_n, sel_1v8 and sel_5v all high in the inactive state, the block enters stop. There, stat_n follows card_det directly. A shutdown in progress always finishes first.
- R13: When any of the three inputs drops in stop, stat_n is held 0 for PU_TICKS ticks. A full presence debounce then starts from zero.
- R14: A low sess_req_n without a debounced card leaves every card output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| sess_req_n | input | 1 | Host session request, active low |
| host_rst | input | 1 | Host reset line for the card |
| sel_1v8 | input | 1 | Selects 1.8 V; has priority |
| sel_5v | input | 1 | Selects 5 V when high, 3 V when low |
| card_det | input | 1 | Raw card-presence level, high = card in |
| fault_ovc | input | 1 | Card supply overcurrent |
| fault_hot | input | 1 | Overtemperature |
| fault_vlow | input | 1 | Host supply low |
| vcc_en | output | 1 | Card supply generator enable |
| vcc_sel | output | 2 | Selected voltage code (00 3 V, 01 5 V, 10 1.8 V) |
| io_en | output | 1 | Card data lines enabled (0 = pulled low) |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset line |
| stat_n | output | 1 | Status/interrupt to host, active low |

## Verification
Each result has a fixed due cycle relative to the input change. Registered results such as vcc_sel, the start of a shutdown and the status flag arrive one cycle after the edge that registers the change. Milestones arrive one cycle plus the stated tick count later. card_rst tracking host_rst and the late clock start arrive in the same cycle. The bench ticks the oscillator every cycle and queues each expectation with its absolute due cycle when it applies a stimulus. The monitor compares only masked fields, half a period after the edge, in exactly that cycle, and it flags any item it finds overdue.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_ON,
    ST_DEACT,
    ST_STOP,
    ST_PWRUP
  } seq_state_e;

  typedef enum logic [1:0] {
    VS_3V0 = 2'b00,
    VS_5V0 = 2'b01,
    VS_1V8 = 2'b10
  } vsel_e;

  function automatic vsel_e pick_vsel(input logic s18, input logic s5);
    if (s18)     return VS_1V8;
    else if (s5) return VS_5V0;
    else         return VS_3V0;
  endfunction

endpackage

// File: rtl/sc_vsel_reg.sv
module sc_vsel_reg
  import sc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_1v8,
  input  logic       sel_5v,
  output logic [1:0] vcc_sel
);
  vsel_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= VS_3V0;
    else        code_q <= pick_vsel(sel_1v8, sel_5v);
  end

  assign vcc_sel = code_q;
endmodule

// File: rtl/sc_pres_filter.sv
module sc_pres_filter #(
  parameter int DEB_TICKS = 20480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic card_det,
  input  logic hold,
  output logic pres_ok
);
  logic ok_q;

  generate
    if (DEB_TICKS <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ok_q <= 1'b0;
        else if (hold || !card_det) ok_q <= 1'b0;
        else if (osc_tick)          ok_q <= 1'b1;
      end
    end else begin : g_count
      localparam int DW = $clog2(DEB_TICKS + 1);
      localparam logic [DW-1:0] LAST = DW'(DEB_TICKS - 1);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ok_q  <= 1'b0;
          cnt_q <= '0;
        end else if (hold || !card_det) begin
          ok_q  <= 1'b0;
          cnt_q <= '0;
        end else if (ok_q) begin
          cnt_q <= '0;
        end else if (osc_tick) begin
          if (cnt_q == LAST) begin
            ok_q  <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign pres_ok = ok_q;
endmodule

// File: rtl/sc_seq_ctrl.sv
module sc_seq_ctrl
  import sc_seq_pkg::*;
#(
  parameter int OSC_PER_T = 64,
  parameter int PU_TICKS  = 563
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sess_req_n,
  input  logic host_rst,
  input  logic sel_1v8,
  input  logic sel_5v,
  input  logic card_det,
  input  logic pres_ok,
  input  logic fault_ovc,
  input  logic fault_hot,
  input  logic fault_vlow,
  output logic hold_pres,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic stat_n
);
  localparam int HALF    = OSC_PER_T / 2;
  localparam int IO_AT   = 8 * HALF;
  localparam int ACT_END = 14 * HALF;
  localparam int CLK_OFF = HALF;
  localparam int IO_OFF  = 2 * HALF;
  localparam int VCC_OFF = 3 * HALF;
  localparam int DE_END  = 4 * HALF;
  localparam int CMAX    = (ACT_END > PU_TICKS) ? ACT_END : PU_TICKS;
  localparam int CW      = $clog2(CMAX + 1);

  localparam logic [CW-1:0] IO_AT_C   = CW'(IO_AT);
  localparam logic [CW-1:0] ACT_LAST  = CW'(ACT_END - 1);
  localparam logic [CW-1:0] CLK_OFF_C = CW'(CLK_OFF);
  localparam logic [CW-1:0] IO_OFF_C  = CW'(IO_OFF);
  localparam logic [CW-1:0] VCC_OFF_C = CW'(VCC_OFF);
  localparam logic [CW-1:0] DE_LAST   = CW'(DE_END - 1);
  localparam logic [CW-1:0] PU_LAST   = CW'(PU_TICKS - 1);

  seq_state_e    state_q;
  logic [CW-1:0] tcnt_q;
  logic          rst_at_start_q;
  logic          clk_seen_q;
  logic          io_seen_q;
  logic          fault_q;

  logic in_sess, fault_any, stop_req, start_ok, act_io, early_clk;

  always_comb begin
    in_sess   = (state_q == ST_ACT) || (state_q == ST_ON);
    fault_any = fault_ovc || fault_hot || fault_vlow || !card_det;
    stop_req  = sess_req_n && sel_1v8 && sel_5v;
    start_ok  = !sess_req_n && pres_ok && !fault_q;
    act_io    = (state_q == ST_ACT) && (tcnt_q >= IO_AT_C);
    early_clk = act_io && (!rst_at_start_q || !host_rst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      tcnt_q         <= '0;
      rst_at_start_q <= 1'b0;
      clk_seen_q     <= 1'b0;
      io_seen_q      <= 1'b0;
      fault_q        <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          tcnt_q     <= '0;
          clk_seen_q <= 1'b0;
          io_seen_q  <= 1'b0;
          if (sess_req_n) fault_q <= 1'b0;
          if (stop_req) begin
            state_q <= ST_STOP;
          end else if (start_ok) begin
            state_q        <= ST_ACT;
            rst_at_start_q <= host_rst;
          end
        end
        ST_ACT, ST_ON: begin
          if (clk_en) clk_seen_q <= 1'b1;
          if (io_en)  io_seen_q  <= 1'b1;
          if (sess_req_n || fault_any) begin
            state_q <= ST_DEACT;
            tcnt_q  <= '0;
            if (fault_any) fault_q <= 1'b1;
          end else if (state_q == ST_ACT && osc_tick) begin
            if (tcnt_q == ACT_LAST) state_q <= ST_ON;
            else                    tcnt_q  <= tcnt_q + 1'b1;
          end
        end
        ST_DEACT: begin
          if (osc_tick) begin
            if (tcnt_q == DE_LAST) begin
              state_q <= ST_IDLE;
              tcnt_q  <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (!stop_req) begin
            state_q <= ST_PWRUP;
            tcnt_q  <= '0;
          end
        end
        ST_PWRUP: begin
          if (osc_tick) begin
            if (tcnt_q == PU_LAST) begin
              state_q <= ST_IDLE;
              tcnt_q  <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hold_pres = (state_q == ST_STOP) || (state_q == ST_PWRUP);
    vcc_en    = in_sess || ((state_q == ST_DEACT) && (tcnt_q < VCC_OFF_C));
    io_en     = act_io || (state_q == ST_ON)
             || ((state_q == ST_DEACT) && io_seen_q && (tcnt_q < IO_OFF_C));
    clk_en    = ((state_q == ST_ACT) && (clk_seen_q || early_clk))
             || (state_q == ST_ON)
             || ((state_q == ST_DEACT) && clk_seen_q && (tcnt_q < CLK_OFF_C));
    card_rst  = (state_q == ST_ON) && host_rst;
    case (state_q)
      ST_STOP:  stat_n = card_det;
      ST_PWRUP: stat_n = 1'b0;
      default:  stat_n = pres_ok && !fault_q;
    endcase
  end
endmodule

// File: rtl/sc_session_seq.sv
module sc_session_seq #(
  parameter int OSC_PER_T = 64,
  parameter int DEB_TICKS = 20480,
  parameter int PU_TICKS  = 563
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       sess_req_n,
  input  logic       host_rst,
  input  logic       sel_1v8,
  input  logic       sel_5v,
  input  logic       card_det,
  input  logic       fault_ovc,
  input  logic       fault_hot,
  input  logic       fault_vlow,
  output logic       vcc_en,
  output logic [1:0] vcc_sel,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       stat_n
);
  logic pres_ok;
  logic hold_pres;

  sc_pres_filter #(.DEB_TICKS(DEB_TICKS)) u_pres (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .card_det(card_det), .hold(hold_pres), .pres_ok(pres_ok)
  );

  sc_vsel_reg u_vsel (
    .clk(clk), .rst_n(rst_n), .sel_1v8(sel_1v8), .sel_5v(sel_5v),
    .vcc_sel(vcc_sel)
  );

  sc_seq_ctrl #(.OSC_PER_T(OSC_PER_T), .PU_TICKS(PU_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .sess_req_n(sess_req_n), .host_rst(host_rst),
    .sel_1v8(sel_1v8), .sel_5v(sel_5v), .card_det(card_det),
    .pres_ok(pres_ok), .fault_ovc(fault_ovc), .fault_hot(fault_hot),
    .fault_vlow(fault_vlow), .hold_pres(hold_pres),
    .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .stat_n(stat_n)
  );
endmodule

// File: rtl/sc_session_seq_chk.sv
module sc_session_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_1v8,
  input logic       card_det,
  input logic       fault_ovc,
  input logic       vcc_en,
  input logic [1:0] vcc_sel,
  input logic       io_en,
  input logic       clk_en,
  input logic       card_rst,
  input logic       stat_n
);
  // R4
  rst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (vcc_en && io_en && clk_en));

  // R3
  io_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  // R5
  clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);

  // R2
  vsel_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_1v8 |=> (vcc_sel == 2'b10));

  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && fault_ovc) |=> (!stat_n && !card_rst));

  // R9
  removal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && !card_det) |=> !stat_n);
endmodule

bind sc_session_seq sc_session_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_1v8(sel_1v8), .card_det(card_det),
  .fault_ovc(fault_ovc), .vcc_en(vcc_en), .vcc_sel(vcc_sel),
  .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .stat_n(stat_n)
);

// File: tb/sc_session_seq_bench.sv
`timescale 1ns/1ps
module sc_session_seq_bench;
  localparam int B_VCC = 6;
  localparam int B_IO  = 3;
  localparam int B_CLK = 2;
  localparam int B_RST = 1;
  localparam int B_OFF = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic sess_req_n = 1'b1;
  logic host_rst = 1'b0;
  logic sel_1v8 = 1'b0;
  logic sel_5v = 1'b0;
  logic card_det = 1'b0;
  logic fault_ovc = 1'b0;
  logic fault_hot = 1'b0;
  logic fault_vlow = 1'b0;
  logic vcc_en, io_en, clk_en, card_rst, stat_n;
  logic [1:0] vcc_sel;

  always #4 clk = ~clk;

  sc_session_seq #(.OSC_PER_T(8), .DEB_TICKS(10), .PU_TICKS(6)) u_sc_session_seq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sess_req_n(sess_req_n),
    .host_rst(host_rst), .sel_1v8(sel_1v8), .sel_5v(sel_5v),
    .card_det(card_det), .fault_ovc(fault_ovc), .fault_hot(fault_hot),
    .fault_vlow(fault_vlow), .vcc_en(vcc_en), .vcc_sel(vcc_sel),
    .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .stat_n(stat_n)
  );

  typedef struct {
    int         at;
    logic [6:0] mask;
    logic [6:0] val;
    string      tag;
  } exp_t;

  exp_t exq[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  wire [6:0] obs = {vcc_en, vcc_sel, io_en, clk_en, card_rst, stat_n};

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = exq.size() - 1; i >= 0; i--) begin
      if (exq[i].at <= cyc) begin
        n_run++;
        if (exq[i].at < cyc || ((obs & exq[i].mask) != exq[i].val)) begin
          n_fail++;
          $display("FAIL %s: cycle %0d actual %b expected %b (mask %b)",
                   exq[i].tag, cyc, obs & exq[i].mask, exq[i].val, exq[i].mask);
        end
        exq.delete(i);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int dly, input logic [6:0] m, input logic [6:0] v, input string tag);
    exp_t e;
    e.at = cyc + dly; e.mask = m; e.val = v; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic exp_bit(input int dly, input int pos, input logic v, input string tag);
    logic [6:0] m;
    m = 7'(1) << pos;
    push(dly, m, v ? m : 7'd0, tag);
  endtask

  task automatic exp_vsel(input int dly, input logic [1:0] v, input string tag);
    push(dly, 7'b0110000, {1'b0, v, 4'b0000}, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: cycle %0d actual running expected finished", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    step(2);
    push(0, 7'h7F, 7'h00, "R1");
    step(2);
    rst_n = 1'b1;
    step(2);

    // R14: request without a card does nothing
    sess_req_n = 1'b0;
    exp_bit(3, B_VCC, 1'b0, "R14");
    exp_bit(3, B_IO, 1'b0, "R14");
    step(5);
    sess_req_n = 1'b1;
    step(2);

    // R8: insertion with a glitch; count restarts
    card_det = 1'b1;
    step(5);
    card_det = 1'b0;
    step(1);
    card_det = 1'b1;
    exp_bit(9, B_OFF, 1'b0, "R8");
    exp_bit(10, B_OFF, 1'b1, "R8");
    step(12);

    // R11: faults ignored outside a session
    fault_ovc = 1'b1; fault_hot = 1'b1;
    exp_bit(1, B_OFF, 1'b1, "R11");
    exp_bit(3, B_OFF, 1'b1, "R11");
    exp_bit(2, B_VCC, 1'b0, "R11");
    step(4);
    fault_ovc = 1'b0; fault_hot = 1'b0;
    step(1);

    // R2: select encoding and latency
    sel_1v8 = 1'b1;
    exp_vsel(1, 2'b10, "R2");
    step(2);
    sel_1v8 = 1'b0; sel_5v = 1'b1;
    exp_vsel(0, 2'b10, "R2");
    exp_vsel(1, 2'b01, "R2");
    step(2);
    sel_5v = 1'b0;
    exp_vsel(1, 2'b00, "R2");
    step(2);
    sel_5v = 1'b1;
    step(2);

    // R3/R4/R5: activation with host reset low at start
    host_rst = 1'b0;
    sess_req_n = 1'b0;
    exp_bit(0, B_VCC, 1'b0, "R3");
    exp_bit(1, B_VCC, 1'b1, "R3");
    exp_bit(32, B_IO, 1'b0, "R3");
    exp_bit(33, B_IO, 1'b1, "R3");
    exp_bit(32, B_CLK, 1'b0, "R5");
    exp_bit(33, B_CLK, 1'b1, "R5");
    exp_bit(56, B_RST, 1'b0, "R4");
    exp_bit(57, B_RST, 1'b1, "R4");
    step(40);
    host_rst = 1'b1;
    step(20);
    host_rst = 1'b0;
    exp_bit(0, B_RST, 1'b0, "R4");
    step(2);
    host_rst = 1'b1;
    exp_bit(0, B_RST, 1'b1, "R4");
    step(2);

    // R6/R7: deactivation; request during it waits, then restarts (R5 late clock)
    sess_req_n = 1'b1;
    exp_bit(0, B_RST, 1'b1, "R6");
    exp_bit(1, B_RST, 1'b0, "R6");
    exp_bit(4, B_CLK, 1'b1, "R6");
    exp_bit(5, B_CLK, 1'b0, "R6");
    exp_bit(8, B_IO, 1'b1, "R6");
    exp_bit(9, B_IO, 1'b0, "R6");
    exp_bit(12, B_VCC, 1'b1, "R6");
    exp_bit(13, B_VCC, 1'b0, "R6");
    exp_bit(16, B_VCC, 1'b0, "R7");
    exp_bit(17, B_VCC, 1'b0, "R7");
    exp_bit(18, B_VCC, 1'b1, "R7");
    exp_bit(50, B_IO, 1'b1, "R5");
    exp_bit(50, B_CLK, 1'b0, "R5");
    exp_bit(54, B_CLK, 1'b0, "R5");
    exp_bit(55, B_CLK, 1'b1, "R5");
    exp_bit(58, B_CLK, 1'b1, "R5");
    exp_bit(74, B_RST, 1'b1, "R4");
    step(5);
    sess_req_n = 1'b0;
    step(50);
    host_rst = 1'b0;
    step(3);
    host_rst = 1'b1;
    step(20);

    // R10: overcurrent in session
    fault_ovc = 1'b1;
    exp_bit(0, B_RST, 1'b1, "R10");
    exp_bit(1, B_RST, 1'b0, "R10");
    exp_bit(0, B_OFF, 1'b1, "R10");
    exp_bit(1, B_OFF, 1'b0, "R10");
    exp_bit(17, B_VCC, 1'b0, "R10");
    exp_bit(20, B_OFF, 1'b0, "R10");
    exp_bit(22, B_VCC, 1'b0, "R10");
    step(1);
    fault_ovc = 1'b0;
    step(21);
    sess_req_n = 1'b1;
    exp_bit(1, B_OFF, 1'b1, "R10");
    step(3);

    // R9: card removed in session
    sess_req_n = 1'b0;
    step(60);
    card_det = 1'b0;
    exp_bit(0, B_RST, 1'b1, "R9");
    exp_bit(1, B_RST, 1'b0, "R9");
    exp_bit(1, B_OFF, 1'b0, "R9");
    exp_bit(9, B_IO, 1'b0, "R9");
    exp_bit(13, B_VCC, 1'b0, "R9");
    exp_bit(21, B_OFF, 1'b0, "R9");
    exp_bit(32, B_OFF, 1'b1, "R8");
    step(20);
    sess_req_n = 1'b1;
    step(2);
    card_det = 1'b1;
    step(33);

    // R12: stop entry; status follows raw presence
    sel_1v8 = 1'b1;
    exp_vsel(1, 2'b10, "R12");
    exp_bit(1, B_OFF, 1'b1, "R12");
    exp_bit(2, B_OFF, 1'b0, "R12");
    exp_bit(3, B_OFF, 1'b1, "R12");
    exp_bit(4, B_VCC, 1'b0, "R12");
    step(2);
    card_det = 1'b0;
    step(1);
    card_det = 1'b1;
    step(2);

    // R13: stop exit holds status, then full debounce
    sel_1v8 = 1'b0;
    exp_vsel(1, 2'b01, "R13");
    exp_bit(1, B_OFF, 1'b0, "R13");
    exp_bit(16, B_OFF, 1'b0, "R13");
    exp_bit(17, B_OFF, 1'b1, "R13");
    step(20);

    wait (exq.size() == 0);
    step(2);
    finish_run();
  end
endmodule